// File: doc/BRIEF.md
# Single-Change Input Sequence Detector

This block watches two input lines, X1 and X2, sampled on a system clock, and raises its output Z once the pair has moved through 00, then 01, then 11 (written as {X1,X2}). Every move must be a single-line change. The detector works in fundamental mode: it accepts one input change at a time. Each accepted change spends a fixed transient interval in an unstable state before the tracker settles and the output updates.

When both lines flip between two consecutive samples, that transition is illegal. The block then raises a one-cycle flag, drops Z and forgets any partial progress. While Z is high, the next input change of any kind clears it. A sample equal to the one before it is not an event.

The reset is asserted asynchronously and released in step with the clock. The first sample taken after reset only sets the reference value. Progress starts only after an input change lands on 00.

Top module: `fmd_seq_detect`

## Requirements
- R1: After reset, z_o and illegal_o are 0 and the tracker holds no progress, whatever value the inputs carry. An input already at 00 when reset is released does not count as the first stage.
- R2: The sequence {X1,X2} = 00, 01, 11 raises z_o. The 00 stage must be reached through an input change. Each step must be a single-bit change.
- R3: A single-bit change sampled on clock edge k takes effect on the tracker and z_o at edge k+TRANSIENT_CYCLES (default k+1). z_o keeps its old value during the transient cycle.
- R4: While z_o is 1, the next single-bit change clears z_o, whatever the new value.
- R5: A change of both bits between consecutive samples sets illegal_o for exactly one cycle, starting on the sampling edge. z_o is 0 from that same edge, and any pending change is discarded. The tracker returns to no progress even if the new value is 00.
- R6: During the build-up, any single-bit change other than 00→01 (from the 00 stage) or 01→11 (from the 01 stage) drops progress. A change that lands on 00 restarts progress at the 00 stage.
- R7: A sample equal to the previous one is not an event. z_o keeps its value and illegal_o stays 0.
- R8: A single-bit change never sets illegal_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| arst_ni | input | 1 | Asynchronous active-low reset |
| x1_i | input | 1 | Input line X1, upper bit of the {X1,X2} pair |
| x2_i | input | 1 | Input line X2, lower bit of the {X1,X2} pair |
| z_o | output | 1 | Sequence-detected output |
| illegal_o | output | 1 | One-cycle pulse on a double input change |

## Verification
Some properties are checked on every cycle: the flag follows every double change and never follows a single change; the flag and Z are never high together; Z cannot move once the inputs have been quiet for longer than the transient interval; and the outputs are idle in the first cycle after reset. Only the bench's scenarios can show the order-dependent behaviour. These include Z rising after exactly 00, 01, 11 and clearing on the change after that, progress lost on a wrong step, and no credit for a 00 present at reset. The bench sweeps every five-value input sequence from reset and compares each step with a sequence-level model.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  // Tracker progress through the 00 -> 01 -> 11 pattern
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ZERO = 2'd1,
    TRK_ONE  = 2'd2,
    TRK_HIT  = 2'd3
  } trk_state_e;

  localparam int unsigned PAIR_W = 2;

  // Pattern stages as {X1,X2}
  localparam logic [PAIR_W-1:0] PAT_FIRST  = 2'b00;
  localparam logic [PAIR_W-1:0] PAT_SECOND = 2'b01;
  localparam logic [PAIR_W-1:0] PAT_THIRD  = 2'b11;

endpackage

// File: rtl/fmd_rst_sync.sv
module fmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= '0;
        else          chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) chain_q <= '0;
        else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = chain_q[LAST];

endmodule

// File: rtl/fmd_chg_detect.sv
module fmd_chg_detect
  import fmd_pkg::*;
#(
  parameter int unsigned TRANSIENT_CYCLES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAIR_W-1:0] x_i,
  output logic              apply_o,
  output logic [PAIR_W-1:0] apply_val_o,
  output logic              flush_o,
  output logic              illegal_o
);

  localparam int unsigned DEPTH = (TRANSIENT_CYCLES < 1) ? 1 : TRANSIENT_CYCLES;

  logic [PAIR_W-1:0] smp_q;
  logic              valid_q;
  logic              illegal_q;
  logic [PAIR_W-1:0] diff;
  logic              single_chg;
  logic              dual_chg;
  logic              smp_en;

  logic [DEPTH-1:0]  pend_vld_q;
  logic [PAIR_W-1:0] pend_val_q [DEPTH];

  // Classify the current sample against the previous one
  always_comb begin
    diff       = x_i ^ smp_q;
    single_chg = valid_q && ($countones(diff) == 1);
    dual_chg   = valid_q && (diff == {PAIR_W{1'b1}});
    smp_en     = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q     <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (smp_en) begin
        smp_q   <= x_i;
        valid_q <= 1'b1;
      end
      illegal_q <= dual_chg;
    end
  end

  // Transient pipeline: each accepted change waits DEPTH cycles
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            pend_vld_q[0] <= 1'b0;
            pend_val_q[0] <= '0;
          end else begin
            pend_vld_q[0] <= single_chg;
            if (single_chg) pend_val_q[0] <= x_i;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            pend_vld_q[i] <= 1'b0;
            pend_val_q[i] <= '0;
          end else begin
            pend_vld_q[i] <= dual_chg ? 1'b0 : pend_vld_q[i-1];
            if (pend_vld_q[i-1]) pend_val_q[i] <= pend_val_q[i-1];
          end
        end
      end
    end
  endgenerate

  assign apply_o     = pend_vld_q[DEPTH-1];
  assign apply_val_o = pend_val_q[DEPTH-1];
  assign flush_o     = dual_chg;
  assign illegal_o   = illegal_q;

endmodule

// File: rtl/fmd_tracker.sv
module fmd_tracker
  import fmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  logic [PAIR_W-1:0] val_i,
  input  logic              flush_i,
  output logic              z_o
);

  trk_state_e st_q;
  trk_state_e st_d;
  logic       st_en;
  logic       at_first;

  always_comb begin
    at_first = (val_i == PAT_FIRST);
    st_en    = flush_i || apply_i;
    st_d     = st_q;
    if (flush_i) begin
      st_d = TRK_IDLE;
    end else if (apply_i) begin
      unique case (st_q)
        TRK_ZERO: st_d = (val_i == PAT_SECOND) ? TRK_ONE :
                         (at_first ? TRK_ZERO : TRK_IDLE);
        TRK_ONE:  st_d = (val_i == PAT_THIRD) ? TRK_HIT :
                         (at_first ? TRK_ZERO : TRK_IDLE);
        TRK_HIT:  st_d = at_first ? TRK_ZERO : TRK_IDLE;
        default:  st_d = at_first ? TRK_ZERO : TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= TRK_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign z_o = (st_q == TRK_HIT);

endmodule

// File: rtl/fmd_seq_detect.sv
module fmd_seq_detect
  import fmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned TRANSIENT_CYCLES = 1
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic x1_i,
  input  logic x2_i,
  output logic z_o,
  output logic illegal_o
);

  logic              rst_n_sync;
  logic [PAIR_W-1:0] pair;
  logic              apply;
  logic [PAIR_W-1:0] apply_val;
  logic              flush;

  assign pair = {x1_i, x2_i};

  fmd_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n_sync)
  );

  fmd_chg_detect #(
    .TRANSIENT_CYCLES (TRANSIENT_CYCLES)
  ) i_chg_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .x_i         (pair),
    .apply_o     (apply),
    .apply_val_o (apply_val),
    .flush_o     (flush),
    .illegal_o   (illegal_o)
  );

  fmd_tracker i_tracker (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .apply_i (apply),
    .val_i   (apply_val),
    .flush_i (flush),
    .z_o     (z_o)
  );

endmodule

// File: rtl/fmd_seq_detect_chk.sv
module fmd_seq_detect_chk #(
  parameter int unsigned TRANSIENT_CYCLES = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] x_i,
  input logic       z_i,
  input logic       illegal_i
);

  localparam int unsigned QMAX = TRANSIENT_CYCLES + 2;
  localparam int unsigned QW   = $clog2(QMAX + 1);

  logic          seen_q;
  logic [1:0]    last_q;
  logic [QW-1:0] quiet_q;
  logic          moved;

  assign moved = seen_q && (x_i != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      last_q  <= '0;
      quiet_q <= '0;
    end else begin
      seen_q <= 1'b1;
      last_q <= x_i;
      if (moved || !seen_q)            quiet_q <= '0;
      else if (quiet_q < QW'(QMAX))    quiet_q <= quiet_q + 1'b1;
    end
  end

  AST_OUT_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!z_i && !illegal_i)); // R1

  AST_DUAL_RAISES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (x_i ^ last_q) == 2'b11) |=> illegal_i); // R5

  AST_FLAG_FORCES_Z_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |-> !z_i); // R5

  AST_SINGLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $countones(x_i ^ last_q) < 2) |=> !illegal_i); // R8

  AST_QUIET_Z_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !moved && quiet_q >= QW'(TRANSIENT_CYCLES)) |=> $stable(z_i)); // R7

endmodule

bind fmd_seq_detect fmd_seq_detect_chk #(
  .TRANSIENT_CYCLES (TRANSIENT_CYCLES)
) i_fmd_seq_detect_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_n_sync),
  .x_i       ({x1_i, x2_i}),
  .z_i       (z_o),
  .illegal_i (illegal_o)
);

// File: tb/test_fmd_seq_detect.sv
module test_fmd_seq_detect;

  logic clk;
  logic arst_n;
  logic x1, x2;
  logic z, illegal;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  fmd_seq_detect i_fmd_seq_detect (
    .clk_i     (clk),
    .arst_ni   (arst_n),
    .x1_i      (x1),
    .x2_i      (x2),
    .z_o       (z),
    .illegal_o (illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  // Sequence-level model: 0 idle, 1 saw 00, 2 saw 01, 3 hit
  function automatic int model_next(input int st, input logic [1:0] prev, input logic [1:0] v);
    logic [1:0] d;
    d = prev ^ v;
    if (d == 2'b11) return 0;
    if (d == 2'b00) return st;
    if (st == 1 && v == 2'b01) return 2;
    if (st == 2 && v == 2'b11) return 3;
    return (v == 2'b00) ? 1 : 0;
  endfunction

  task automatic run_seq(input int code);
    logic [1:0] vals [5];
    logic [1:0] prev;
    int st;
    int nst;
    bit zold;
    bit znew;
    bit dual;
    bit same;
    string tag;
    for (int j = 0; j < 5; j++) vals[j] = 2'((code >> (2 * j)) & 3);

    @(negedge clk);
    arst_n = 1'b0;
    {x1, x2} = vals[0];
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(z == 1'b0, "R1 z after reset", int'(z), 0);
    check(illegal == 1'b0, "R1 flag after reset", int'(illegal), 0);

    prev = vals[0];
    st   = 0;
    for (int j = 1; j < 5; j++) begin
      zold = (st == 3);
      nst  = model_next(st, prev, vals[j]);
      znew = (nst == 3);
      dual = ((prev ^ vals[j]) == 2'b11);
      same = (prev == vals[j]);
      {x1, x2} = vals[j];
      @(posedge clk);
      @(negedge clk);
      if (dual)      check(illegal == 1'b1, "R5 flag raised", int'(illegal), 1);
      else if (same) check(illegal == 1'b0, "R7 no flag when unchanged", int'(illegal), 0);
      else           check(illegal == 1'b0, "R8 no flag on single change", int'(illegal), 0);
      if (dual)      check(z == 1'b0, "R5 z cleared at once", int'(z), 0);
      else if (same) check(z == zold, "R7 z holds", int'(z), int'(zold));
      else           check(z == zold, "R3 z holds in transient cycle", int'(z), int'(zold));
      @(posedge clk);
      @(negedge clk);
      check(illegal == 1'b0, "R5 flag lasts one cycle", int'(illegal), 0);
      if (dual)       tag = "R5 z after double change";
      else if (same)  tag = "R7 z after no change";
      else if (zold)  tag = "R4 z cleared by next change";
      else if (znew)  tag = "R2 z raised by sequence";
      else            tag = "R6 progress tracking";
      check(z == znew, tag, int'(z), int'(znew));
      st   = nst;
      prev = vals[j];
    end
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    arst_n = 1'b0;
    x1     = 1'b0;
    x2     = 1'b0;
    repeat (3) @(negedge clk);
    for (int code = 0; code < 1024; code++) run_seq(code);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule